// File: doc/BRIEF.md
# Three-Level Address Translation Walker

The block turns a 32-bit linear address into a 36-bit physical address. It does this by reading up to three levels of translation tables from memory. The first level is a small root table of four 64-bit entries. The root table's location comes from a 27-bit base input, which gives a 32-byte-aligned byte address below 4 GB. The second level is a 512-entry directory and the third is a 512-entry leaf table. Both are 4 KB in size and hold 64-bit entries. A directory entry can end the walk early and map a 2 MB page. When translation is turned off, the block returns the linear address zero-extended and does not touch memory.

Requests arrive on a valid/ready port. The walker accepts a request only when it is idle, holding `req_ready` high. While a walk is in progress or a result is still waiting to be taken, `req_ready` stays low. The result port is also valid/ready. When `rsp_ready` is low, the block holds the result and every result field stays unchanged until the result is taken. Table entries are fetched through a simple read port. The block pulses `mem_req` for one cycle with `mem_addr`, then waits for `mem_rvalid`, which carries `mem_rdata`. Only one read is outstanding at any time.

Top module: `xlate_walker`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0 and `mem_req` is 0.
- R2: A request is taken on a cycle where both `req_valid` and `req_ready` are 1. `req_ready` is 1 only while no walk is running and no result is pending.
- R3: While `rsp_valid` is 1 and `rsp_ready` is 0, `rsp_valid`, `rsp_paddr`, `rsp_fault` and `rsp_level` hold their values. One cycle with `rsp_ready` high clears `rsp_valid` and brings `req_ready` back to 1.
- R4: If `xl_en` is 0 on the accepting cycle, the result is `{4'b0, laddr}` with `rsp_fault`=0 and `rsp_level`=0. No memory read is issued, and `rsp_valid` rises in the cycle after acceptance.
- R5: The first read goes to `{root_base, 5'b0} + laddr[31:30]*8`.
- R6: The second read goes to `{root_entry[35:12], 12'b0} + laddr[29:21]*8`.
- R7: If bit 7 of the directory entry is 0, the third read goes to `{dir_entry[35:12], 12'b0} + laddr[20:12]*8`. The result is then `{leaf_entry[35:12], laddr[11:0]}` with `rsp_level`=2.
- R8: If bit 7 of the directory entry is 1, no third read is made. The result is `{dir_entry[35:21], laddr[20:0]}` with `rsp_level`=1.
- R9: If bit 0 (present) of a fetched entry is 0, the walk stops with no further reads. The result then has `rsp_fault`=1, `rsp_paddr`=0 and `rsp_level` equal to the failing level: 0 for root, 1 for directory, 2 for leaf. A successful walk gives `rsp_fault`=0.
- R10: `mem_req` lasts one cycle, and no new read is issued until `mem_rvalid` has returned the previous one.
- R11: When read data returns L cycles after the `mem_req` cycle (L ≥ 1), each level read costs L+1 cycles. `rsp_valid` therefore rises (L+1)×(number of reads) cycles after the accepting edge.
- R12: Bit 7 is honoured only in directory entries. Bit 7 set in a root or leaf entry does not change the walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xl_en | input | 1 | Translation enable, sampled when a request is accepted |
| root_base | input | 27 | Root table base, byte address divided by 32 |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Walker can accept a request |
| req_laddr | input | 32 | Linear address to translate |
| rsp_valid | output | 1 | Result valid |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_paddr | output | 36 | Physical address (0 on a fault) |
| rsp_fault | output | 1 | Walk hit an entry that is not present |
| rsp_level | output | 2 | Failing level on a fault, otherwise the last level read |
| mem_req | output | 1 | One-cycle read strobe |
| mem_addr | output | 36 | Byte address of the entry to read |
| mem_rdata | input | 64 | Entry data returned by memory |
| mem_rvalid | input | 1 | Returned data is valid |

## Verification
The bench's memory model answers one cycle after the request cycle. It can add a programmable number of extra wait cycles. With a per-read latency of L, the result is due (L+1) cycles per level read after the accepting edge. That is 0 cycles for a bypassed request, 2L+2 for a 2 MB page and 3L+3 for a full walk. The fault case has one read per level reached. Each scenario counts the falling edges on which `rsp_valid` is still low after acceptance and compares that count with this formula before it checks any result field. All outputs are sampled at falling edges, so each register stage shows up as a whole cycle in the count.

// File: rtl/xw_pkg.sv
package xw_pkg;
  localparam int LA_W       = 32;
  localparam int PA_W       = 36;
  localparam int ENT_W      = 64;
  localparam int OFF_W      = 12;
  localparam int IDX_W      = 9;
  localparam int TOP_W      = 2;
  localparam int ENT_SH     = 3;
  localparam int PRES_BIT   = 0;
  localparam int PS_BIT     = 7;
  localparam int LVL_W      = 2;
  localparam int ROOT_ALIGN = TOP_W + ENT_SH;
  localparam int RB_W       = LA_W - ROOT_ALIGN;
  localparam int FRM_W      = PA_W - OFF_W;
  localparam int BIG_OFF_W  = OFF_W + IDX_W;
  localparam int PAD_W      = PA_W - LA_W;
  localparam int DIR_LSB    = BIG_OFF_W;
  localparam int LEAF_LSB   = OFF_W;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ROOT, ST_DIR, ST_LEAF, ST_DONE, ST_FAULT
  } walk_st_e;
endpackage

// File: rtl/xw_addr_gen.sv
module xw_addr_gen
  import xw_pkg::*;
(
  input  walk_st_e          st,
  input  logic [RB_W-1:0]   root_base,
  input  logic [LA_W-1:0]   laddr,
  input  logic [FRM_W-1:0]  tbl_frame,
  output logic [PA_W-1:0]   ent_addr
);
  logic [IDX_W-1:0] dir_idx;
  logic [IDX_W-1:0] leaf_idx;
  logic [TOP_W-1:0] top_idx;
  logic             unused_low;

  assign top_idx    = laddr[LA_W-1 -: TOP_W];
  assign dir_idx    = laddr[DIR_LSB +: IDX_W];
  assign leaf_idx   = laddr[LEAF_LSB +: IDX_W];
  assign unused_low = ^laddr[OFF_W-1:0];

  always_comb begin
    case (st)
      ST_ROOT: ent_addr = {{PAD_W{1'b0}}, root_base, top_idx, {ENT_SH{1'b0}}};
      ST_DIR:  ent_addr = {tbl_frame, dir_idx, {ENT_SH{1'b0}}};
      ST_LEAF: ent_addr = {tbl_frame, leaf_idx, {ENT_SH{1'b0}}};
      default: ent_addr = '0;
    endcase
  end
endmodule

// File: rtl/xw_entry_eval.sv
module xw_entry_eval
  import xw_pkg::*;
(
  input  walk_st_e          st,
  input  logic [ENT_W-1:0]  rdata,
  input  logic [LA_W-1:0]   laddr,
  output logic              present,
  output logic              big_page,
  output logic [FRM_W-1:0]  nxt_frame,
  output logic [PA_W-1:0]   leaf_paddr,
  output logic [PA_W-1:0]   big_paddr,
  output logic [LVL_W-1:0]  cur_level
);
  logic unused_ent;
  logic unused_la;

  assign unused_ent = ^{rdata[ENT_W-1:PA_W], rdata[OFF_W-1:0]};
  assign unused_la  = ^laddr[LA_W-1:BIG_OFF_W];

  assign present    = rdata[PRES_BIT];
  // page-size flag only means something at the directory level
  assign big_page   = (st == ST_DIR) && rdata[PS_BIT];
  assign nxt_frame  = rdata[PA_W-1:OFF_W];
  assign leaf_paddr = {rdata[PA_W-1:OFF_W], laddr[OFF_W-1:0]};
  assign big_paddr  = {rdata[PA_W-1:BIG_OFF_W], laddr[BIG_OFF_W-1:0]};

  always_comb begin
    case (st)
      ST_DIR:  cur_level = LVL_W'(1);
      ST_LEAF: cur_level = LVL_W'(2);
      default: cur_level = LVL_W'(0);
    endcase
  end
endmodule

// File: rtl/xw_ctrl.sv
module xw_ctrl
  import xw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xl_en,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [LA_W-1:0]   req_laddr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [PA_W-1:0]   rsp_paddr,
  output logic              rsp_fault,
  output logic [LVL_W-1:0]  rsp_level,
  output logic              mem_req,
  input  logic              mem_rvalid,
  output walk_st_e          st,
  output logic [LA_W-1:0]   laddr_q,
  output logic [FRM_W-1:0]  frame_q,
  input  logic              present,
  input  logic              big_page,
  input  logic [FRM_W-1:0]  nxt_frame,
  input  logic [PA_W-1:0]   leaf_paddr,
  input  logic [PA_W-1:0]   big_paddr,
  input  logic [LVL_W-1:0]  cur_level
);
  logic             issued;
  logic [PA_W-1:0]  paddr_q;
  logic             fault_q;
  logic [LVL_W-1:0] level_q;
  logic             walking;

  assign walking   = (st == ST_ROOT) || (st == ST_DIR) || (st == ST_LEAF);
  assign req_ready = (st == ST_IDLE);
  assign mem_req   = walking && !issued;
  assign rsp_valid = (st == ST_DONE) || (st == ST_FAULT);
  assign rsp_paddr = paddr_q;
  assign rsp_fault = fault_q;
  assign rsp_level = level_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      issued  <= 1'b0;
      laddr_q <= '0;
      frame_q <= '0;
      paddr_q <= '0;
      fault_q <= 1'b0;
      level_q <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (req_valid) begin
            laddr_q <= req_laddr;
            fault_q <= 1'b0;
            level_q <= '0;
            issued  <= 1'b0;
            if (xl_en) begin
              st <= ST_ROOT;
            end else begin
              paddr_q <= {{PAD_W{1'b0}}, req_laddr};
              st      <= ST_DONE;
            end
          end
        end
        ST_ROOT, ST_DIR, ST_LEAF: begin
          if (!issued) begin
            issued <= 1'b1;
          end else if (mem_rvalid) begin
            issued <= 1'b0;
            if (!present) begin
              fault_q <= 1'b1;
              level_q <= cur_level;
              paddr_q <= '0;
              st      <= ST_FAULT;
            end else if (st == ST_ROOT) begin
              frame_q <= nxt_frame;
              st      <= ST_DIR;
            end else if (st == ST_DIR) begin
              if (big_page) begin
                paddr_q <= big_paddr;
                level_q <= cur_level;
                st      <= ST_DONE;
              end else begin
                frame_q <= nxt_frame;
                st      <= ST_LEAF;
              end
            end else begin
              paddr_q <= leaf_paddr;
              level_q <= cur_level;
              st      <= ST_DONE;
            end
          end
        end
        ST_DONE, ST_FAULT: begin
          if (rsp_ready) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R10: a read strobe never lasts two cycles
  a_r10_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);

  // R10: no new read while the previous one is still awaited
  a_r10_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    (walking && issued && !mem_rvalid) |=> !mem_req);

  // R3: a pending result holds still under back-pressure
  a_r3_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr)
      && $stable(rsp_fault) && $stable(rsp_level)));

  // R2: ready only when nothing is running or pending
  a_r2_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!rsp_valid && !mem_req));

  // R4: bypassed request answers next cycle without a fault
  a_r4_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !xl_en) |=> (rsp_valid && !rsp_fault && !mem_req));

  // R9: a fault carries a zero address and a level in range
  a_r9_fault_shape: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_paddr == '0 && rsp_level <= LVL_W'(2)));
endmodule

// File: rtl/xlate_walker.sv
module xlate_walker
  import xw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xl_en,
  input  logic [RB_W-1:0]   root_base,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [LA_W-1:0]   req_laddr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [PA_W-1:0]   rsp_paddr,
  output logic              rsp_fault,
  output logic [LVL_W-1:0]  rsp_level,
  output logic              mem_req,
  output logic [PA_W-1:0]   mem_addr,
  input  logic [ENT_W-1:0]  mem_rdata,
  input  logic              mem_rvalid
);
  walk_st_e          st;
  logic [LA_W-1:0]   laddr_q;
  logic [FRM_W-1:0]  frame_q;
  logic              present;
  logic              big_page;
  logic [FRM_W-1:0]  nxt_frame;
  logic [PA_W-1:0]   leaf_paddr;
  logic [PA_W-1:0]   big_paddr;
  logic [LVL_W-1:0]  cur_level;

  xw_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .xl_en      (xl_en),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_laddr  (req_laddr),
    .rsp_valid  (rsp_valid),
    .rsp_ready  (rsp_ready),
    .rsp_paddr  (rsp_paddr),
    .rsp_fault  (rsp_fault),
    .rsp_level  (rsp_level),
    .mem_req    (mem_req),
    .mem_rvalid (mem_rvalid),
    .st         (st),
    .laddr_q    (laddr_q),
    .frame_q    (frame_q),
    .present    (present),
    .big_page   (big_page),
    .nxt_frame  (nxt_frame),
    .leaf_paddr (leaf_paddr),
    .big_paddr  (big_paddr),
    .cur_level  (cur_level)
  );

  xw_addr_gen u_addr (
    .st        (st),
    .root_base (root_base),
    .laddr     (laddr_q),
    .tbl_frame (frame_q),
    .ent_addr  (mem_addr)
  );

  xw_entry_eval u_eval (
    .st         (st),
    .rdata      (mem_rdata),
    .laddr      (laddr_q),
    .present    (present),
    .big_page   (big_page),
    .nxt_frame  (nxt_frame),
    .leaf_paddr (leaf_paddr),
    .big_paddr  (big_paddr),
    .cur_level  (cur_level)
  );
endmodule

// File: tb/tb_xlate_walker.sv
module tb_xlate_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        xl_en = 1'b0;
  logic [26:0] root_base = 27'h0123456;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_laddr = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [35:0] rsp_paddr;
  logic        rsp_fault;
  logic [1:0]  rsp_level;
  logic        mem_req;
  logic [35:0] mem_addr;
  logic [63:0] mem_rdata = '0;
  logic        mem_rvalid = 1'b0;

  int total = 0;
  int bad = 0;

  logic [63:0] mem [logic [35:0]];
  logic [35:0] rd_log [16];
  int          rd_cnt = 0;
  int          lat_extra = 0;
  int          pend_cnt = 0;
  logic        pend = 1'b0;
  logic [35:0] pend_addr = '0;
  logic        outstanding = 1'b0;
  int          overlap = 0;

  always #5 clk = ~clk;

  xlate_walker dut (
    .clk(clk), .rst_n(rst_n), .xl_en(xl_en), .root_base(root_base),
    .req_valid(req_valid), .req_ready(req_ready), .req_laddr(req_laddr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr),
    .rsp_fault(rsp_fault), .rsp_level(rsp_level), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid)
  );

  function automatic logic [63:0] rd_mem(logic [35:0] a);
    if (mem.exists(a)) return mem[a];
    return 64'h0;
  endfunction

  // memory model: data one cycle after the strobe, plus lat_extra cycles
  always @(posedge clk) begin
    if (!rst_n) begin
      mem_rvalid  <= 1'b0;
      pend        <= 1'b0;
      outstanding <= 1'b0;
    end else begin
      mem_rvalid <= 1'b0;
      if (mem_req) begin
        if (outstanding) overlap <= overlap + 1;
        rd_log[rd_cnt % 16] <= mem_addr;
        rd_cnt <= rd_cnt + 1;
        if (lat_extra == 0) begin
          mem_rvalid  <= 1'b1;
          mem_rdata   <= rd_mem(mem_addr);
          outstanding <= 1'b0;
        end else begin
          pend        <= 1'b1;
          pend_cnt    <= lat_extra;
          pend_addr   <= mem_addr;
          outstanding <= 1'b1;
        end
      end else if (pend) begin
        if (pend_cnt == 1) begin
          mem_rvalid  <= 1'b1;
          mem_rdata   <= rd_mem(pend_addr);
          pend        <= 1'b0;
          outstanding <= 1'b0;
        end else begin
          pend_cnt <= pend_cnt - 1;
        end
      end
    end
  end

  task automatic chk(input string r, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", r, what, act, exp);
    end
  endtask

  function automatic logic [35:0] root_at(int idx);
    return (36'(root_base) << 5) + 36'(idx * 8);
  endfunction

  function automatic logic [35:0] tbl_at(logic [23:0] frame, int idx);
    return (36'(frame) << 12) + 36'(idx * 8);
  endfunction

  function automatic logic [63:0] ent(logic [23:0] frame, logic [11:0] flags);
    return {28'hA5A5A5A, frame, flags};
  endfunction

  task automatic do_walk(input string ptag, input logic en, input logic [31:0] la,
                         input int extra, input int hold,
                         input logic [35:0] exp_pa, input logic exp_flt,
                         input logic [1:0] exp_lvl, input int exp_rd,
                         input logic [35:0] a0, input logic [35:0] a1,
                         input logic [35:0] a2);
    int base;
    int cyc;
    int busy_bad;
    int hold_bad;
    logic [35:0] pa0;
    logic [35:0] exp_a [3];
    string atag [3];
    exp_a[0] = a0; exp_a[1] = a1; exp_a[2] = a2;
    atag[0] = "R5"; atag[1] = "R6"; atag[2] = "R7";
    @(negedge clk);
    xl_en = en; req_laddr = la; req_valid = 1'b1; lat_extra = extra;
    base = rd_cnt;
    chk("R2", "ready before accept", 64'(req_ready), 64'h1);
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 0; busy_bad = 0;
    while (!rsp_valid && cyc < 200) begin
      cyc++;
      if (req_ready) busy_bad++;
      @(negedge clk);
    end
    chk("R11", "cycles to result", 64'(cyc), 64'(exp_rd * (2 + extra)));
    chk("R2", "ready low while busy", 64'(busy_bad), 64'h0);
    chk("R2", "ready low with result", 64'(req_ready), 64'h0);
    chk(ptag, "paddr", 64'(rsp_paddr), 64'(exp_pa));
    chk("R9", "fault flag", 64'(rsp_fault), 64'(exp_flt));
    chk("R9", "level", 64'(rsp_level), 64'(exp_lvl));
    chk("R10", "read count", 64'(rd_cnt - base), 64'(exp_rd));
    for (int i = 0; i < exp_rd; i++)
      chk(atag[i], "entry address", 64'(rd_log[(base + i) % 16]), 64'(exp_a[i]));
    if (hold > 0) begin
      pa0 = rsp_paddr; hold_bad = 0;
      for (int k = 0; k < hold; k++) begin
        @(negedge clk);
        if (!rsp_valid || rsp_paddr !== pa0 || rsp_fault !== exp_flt ||
            rsp_level !== exp_lvl || req_ready) hold_bad++;
      end
      chk("R3", "result held under back-pressure", 64'(hold_bad), 64'h0);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk("R3", "valid drops after take", 64'(rsp_valid), 64'h0);
    chk("R3", "ready back after take", 64'(req_ready), 64'h1);
  endtask

  localparam logic [23:0] D_A = 24'h400010;
  localparam logic [23:0] L_A = 24'h800200;
  localparam logic [23:0] P_A = 24'hF12345;
  localparam logic [23:0] D_B = 24'h400020;
  localparam logic [23:0] B_F = 24'hC006FF;
  localparam logic [23:0] D_C = 24'h400030;
  localparam logic [23:0] L_D = 24'h800300;

  task automatic t_reset();
    chk("R1", "req_ready after reset", 64'(req_ready), 64'h1);
    chk("R1", "rsp_valid after reset", 64'(rsp_valid), 64'h0);
    chk("R1", "mem_req after reset", 64'(mem_req), 64'h0);
  endtask

  task automatic t_bypass();
    logic [31:0] la;
    la = 32'hDEADBEEF;
    do_walk("R4", 1'b0, la, 0, 0, {4'h0, la}, 1'b0, 2'd0, 0, '0, '0, '0);
  endtask

  task automatic t_small_page(input int extra, input int hold, input logic [11:0] off);
    logic [31:0] la;
    la = {2'd2, 9'h1A5, 9'h0C3, off};
    // leaf entry has bit 7 set: R12 says it must not matter
    do_walk("R7", 1'b1, la, extra, hold, (36'(P_A) << 12) | 36'(off), 1'b0, 2'd2, 3,
            root_at(2), tbl_at(D_A, 'h1A5), tbl_at(L_A, 'h0C3));
  endtask

  task automatic t_big_page();
    logic [31:0] la;
    logic [35:0] exp;
    la  = {2'd1, 9'h033, 21'h1ABCDE};
    exp = ((36'(B_F) << 12) & ~36'h1FFFFF) | 36'(la[20:0]);
    // root entry has bit 7 set: R12 says the walk still reaches the directory
    do_walk("R8", 1'b1, la, 0, 2, exp, 1'b0, 2'd1, 2,
            root_at(1), tbl_at(D_B, 'h033), '0);
    chk("R12", "root size flag ignored, directory read", 64'(rd_log[(rd_cnt - 1) % 16]),
        64'(tbl_at(D_B, 'h033)));
  endtask

  task automatic t_faults();
    do_walk("R9", 1'b1, {2'd3, 30'h0ABCDEF}, 0, 0, '0, 1'b1, 2'd0, 1,
            root_at(3), '0, '0);
    do_walk("R9", 1'b1, {2'd0, 9'h005, 9'h011, 12'h123}, 1, 0, '0, 1'b1, 2'd1, 2,
            root_at(0), tbl_at(D_C, 'h005), '0);
    do_walk("R9", 1'b1, {2'd2, 9'h1A6, 9'h007, 12'h456}, 0, 3, '0, 1'b1, 2'd2, 3,
            root_at(2), tbl_at(D_A, 'h1A6), tbl_at(L_D, 'h007));
  endtask

  initial begin
    int wd;
    for (wd = 0; wd < 100000; wd++) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    mem[root_at(2)]            = ent(D_A, 12'h003);
    mem[tbl_at(D_A, 'h1A5)]    = ent(L_A, 12'h003);
    mem[tbl_at(L_A, 'h0C3)]    = ent(P_A, 12'h083);
    mem[root_at(1)]            = ent(D_B, 12'h083);
    mem[tbl_at(D_B, 'h033)]    = ent(B_F, 12'h083);
    mem[root_at(0)]            = ent(D_C, 12'h001);
    mem[tbl_at(D_A, 'h1A6)]    = ent(L_D, 12'h001);
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_bypass();
    t_small_page(0, 0, 12'h7F4);
    t_big_page();
    t_faults();
    t_small_page(3, 4, 12'h00A);
    t_small_page(1, 0, 12'hFFF);
    t_bypass();
    chk("R10", "overlapping reads seen", 64'(overlap), 64'h0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule